// File: doc/BRIEF.md
# Sub-word Big-Endian Memory Port

This block is a word-organised data store of 64-bit words behind a byte-addressed load/store port. Each request gives a byte address, an access size of 1, 2, 4 or 8 bytes, and store data for stores. The byte address is split into a word index and a byte offset within the word. Bytes within a word are numbered from the most significant end, so byte offset 0 is the top byte of the word.

A load returns the addressed lane shifted down to the least significant end of the output, with zeros above it, one cycle after the request. An 8-byte store overwrites the word in a single cycle. A narrower store reads the word, replaces only the addressed lane and writes the word back. This takes a second cycle, and the port reports busy during that cycle. A request whose offset is not a multiple of its size is rejected. It then leaves memory untouched and raises an error flag for one cycle.

Top module: `bemem_port`

## Requirements
- R1: The byte address is 11 bits wide. Bits [10:3] select one of 256 words and bits [2:0] give the byte offset inside the word. Words with different indices are independent.
- R2: The size code on `req_size` selects the access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. For an aligned load accepted in cycle T, `rd_valid` is 1 in cycle T+1. In that cycle `rd_data` holds word bytes offset .. offset+n-1, with byte offset 0 being word bits [63:56], packed with the lowest-offset byte most significant and right-justified, and upper bits zero.
- R3: A word that has not been written since reset reads as zero at every size and offset.
- R4: A request whose byte offset is not a multiple of its size gives `mis_err` = 1 for exactly one cycle, in cycle T+1. In that cycle `rd_valid` = 0 and `rd_data` = 0, and memory is not changed.
- R5: An aligned store of 1, 2 or 4 bytes replaces only the addressed bytes of the word and keeps the others. `busy` is 1 in cycle T+1 and 0 again in cycle T+2.
- R6: An aligned 8-byte store replaces the whole word in a single cycle and never raises `busy`.
- R7: A store of n bytes uses only `req_wdata[8n-1:0]`. Higher bits of the store data have no effect on memory.
- R8: A request presented while `busy` is 1 is ignored. It writes nothing and produces no `rd_valid` or `mis_err`.
- R9: Directly after reset, `busy`, `rd_valid`, `mis_err` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 11 | Byte address |
| req_size | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:8B) |
| req_wdata | input | 64 | Store data, right-justified |
| busy | output | 1 | Narrow-store write-back in progress; requests ignored |
| rd_valid | output | 1 | Load data valid |
| rd_data | output | 64 | Right-justified load data (zero when not valid) |
| mis_err | output | 1 | Misaligned request rejected |

## Verification
A wrong lane shift or mask shows up at the next load of the same word. The value read back is then either byte-swapped relative to its offset or has the wrong neighbouring bytes. A bad merge in the write-back cycle corrupts bytes that the store should have kept, so the bench reloads whole words after narrow stores. Memory rejected by a misaligned or busy-cycle request is read back right afterwards. An unintended write therefore appears within two cycles of the offending request. A stuck state machine shows at once, because `busy` stays high or never rises one cycle after an aligned narrow store.

// File: rtl/bemem_pkg.sv
package bemem_pkg;
    localparam int WORD_BYTES = 8;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = WORD_BYTES * BYTE_W;
    localparam int OFF_W      = $clog2(WORD_BYTES);
    localparam int SHIFT_W    = $clog2(WORD_W);
    localparam int SIZE_W     = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [SIZE_W-1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } size_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_MERGE = 1'b1
    } state_e;

    // Placement of one lane inside a word
    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        word_t              mask;
    } lane_t;

    function automatic int unsigned size_bytes(size_e sz);
        return 32'd1 << sz;
    endfunction

    // Big-endian lane: offset 0 is the most significant byte
    function automatic lane_t lane_of(size_e sz, logic [OFF_W-1:0] off);
        lane_t       l;
        int unsigned nb;
        nb      = size_bytes(sz);
        l.shift = SHIFT_W'((WORD_BYTES - nb - int'(off)) * BYTE_W);
        l.mask  = {WORD_W{1'b1}} >> (WORD_W - nb * BYTE_W);
        return l;
    endfunction

    function automatic logic is_aligned(size_e sz, logic [OFF_W-1:0] off);
        logic ok;
        unique case (sz)
            SZ_1B:   ok = 1'b1;
            SZ_2B:   ok = (off[0] == 1'b0);
            SZ_4B:   ok = (off[1:0] == 2'b00);
            default: ok = (off == '0);
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/bemem_decode.sv
module bemem_decode
    import bemem_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int ADDR_W = IDX_W + OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [IDX_W-1:0]  idx,
    output logic              aligned,
    output logic              full,
    output lane_t             lane
);
    logic [OFF_W-1:0] off;
    size_e            sz;

    always_comb begin
        sz      = size_e'(size);
        idx     = addr[ADDR_W-1:OFF_W];
        off     = addr[OFF_W-1:0];
        aligned = is_aligned(sz, off);
        full    = (sz == SZ_8B);
        lane    = lane_of(sz, off);
    end
endmodule

// File: rtl/bemem_lane.sv
module bemem_lane
    import bemem_pkg::*;
(
    input  word_t word_in,
    input  lane_t lane,
    input  word_t st_data,
    output word_t ld_data,
    output word_t merged
);
    word_t placed_mask;
    word_t placed_data;

    always_comb begin
        placed_mask = lane.mask << lane.shift;
        placed_data = (st_data & lane.mask) << lane.shift;
        ld_data     = (word_in & placed_mask) >> lane.shift;
        merged      = (word_in & ~placed_mask) | placed_data;
    end
endmodule

// File: rtl/bemem_ram.sv
module bemem_ram
    import bemem_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             re,
    input  logic [IDX_W-1:0] raddr,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  word_t            wdata,
    output word_t            rdata
);
    word_t            mem [DEPTH];
    logic [DEPTH-1:0] written;
    word_t            dout_q;
    logic             wr_q;

    // Storage array: no reset
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            dout_q <= mem[raddr];
        end
    end

    // Per-word written flags so never-written words read as zero
    always_ff @(posedge clk) begin
        if (rst) begin
            written <= '0;
            wr_q    <= 1'b0;
        end else begin
            if (we) begin
                written[waddr] <= 1'b1;
            end
            if (re) begin
                wr_q <= written[raddr];
            end
        end
    end

    assign rdata = wr_q ? dout_q : '0;
endmodule

// File: rtl/bemem_port.sv
module bemem_port
    import bemem_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int ADDR_W = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              mis_err
);
    state_e           state_q;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_aligned;
    logic             dec_full;
    lane_t            dec_lane;

    logic [IDX_W-1:0] pend_idx_q;
    lane_t            lane_q;
    word_t            pend_data_q;
    logic             load_q;
    logic             err_q;

    logic             accept;
    logic             go_load;
    logic             go_full;
    logic             go_narrow;
    logic             go_err;

    logic             ram_re;
    logic             ram_we;
    logic [IDX_W-1:0] ram_waddr;
    word_t            ram_wdata;
    word_t            ram_rdata;
    word_t            lane_ld;
    word_t            lane_merged;

    bemem_decode #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
        .addr    (req_addr),
        .size    (req_size),
        .idx     (dec_idx),
        .aligned (dec_aligned),
        .full    (dec_full),
        .lane    (dec_lane)
    );

    always_comb begin
        accept    = req_valid && (state_q == ST_IDLE);
        go_err    = accept && !dec_aligned;
        go_load   = accept && dec_aligned && !req_store;
        go_full   = accept && dec_aligned && req_store && dec_full;
        go_narrow = accept && dec_aligned && req_store && !dec_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            load_q      <= 1'b0;
            err_q       <= 1'b0;
            pend_idx_q  <= '0;
            lane_q      <= '0;
            pend_data_q <= '0;
        end else begin
            load_q <= go_load;
            err_q  <= go_err;
            if (go_load || go_narrow) begin
                lane_q <= dec_lane;
            end
            if (go_narrow) begin
                pend_idx_q  <= dec_idx;
                pend_data_q <= req_wdata;
            end
            unique case (state_q)
                ST_IDLE:  state_q <= go_narrow ? ST_MERGE : ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ram_re = go_load || go_narrow;
        if (state_q == ST_MERGE) begin
            ram_we    = 1'b1;
            ram_waddr = pend_idx_q;
            ram_wdata = lane_merged;
        end else begin
            ram_we    = go_full;
            ram_waddr = dec_idx;
            ram_wdata = req_wdata;
        end
    end

    bemem_ram #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .re    (ram_re),
        .raddr (dec_idx),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    bemem_lane u_lane (
        .word_in (ram_rdata),
        .lane    (lane_q),
        .st_data (pend_data_q),
        .ld_data (lane_ld),
        .merged  (lane_merged)
    );

    assign busy     = (state_q == ST_MERGE);
    assign rd_valid = load_q;
    assign rd_data  = load_q ? lane_ld : '0;
    assign mis_err  = err_q;
endmodule

// File: rtl/bemem_port_checks.sv
module bemem_port_checks
    import bemem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_store,
    input logic [ADDR_W-1:0] req_addr,
    input logic [SIZE_W-1:0] req_size,
    input logic              busy,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_data,
    input logic              mis_err
);
    logic [2:0] low_mask;
    logic       req_ok;
    logic       taken;

    always_comb begin
        low_mask = 3'((32'd1 << req_size) - 32'd1);
        req_ok   = (req_addr[2:0] & low_mask) == 3'b000;
        taken    = req_valid && !busy;
    end

    a_r2_load_valid: assert property (@(posedge clk) disable iff (rst)
        (taken && !req_store && req_ok) |=> (rd_valid && !mis_err));

    a_r4_err_flag: assert property (@(posedge clk) disable iff (rst)
        (taken && !req_ok) |=> (mis_err && !rd_valid));

    a_r4_err_zero: assert property (@(posedge clk) disable iff (rst)
        mis_err |-> (rd_data == '0 && !rd_valid));

    a_r5_busy_rise: assert property (@(posedge clk) disable iff (rst)
        (taken && req_store && req_ok && req_size != 2'd3) |=> busy);

    a_r5_busy_single: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    a_r6_full_no_busy: assert property (@(posedge clk) disable iff (rst)
        (taken && req_store && req_ok && req_size == 2'd3) |=> !busy);

    a_r8_busy_quiet: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!rd_valid && !mis_err));

    a_r9_rdata_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0));
endmodule

bind bemem_port bemem_port_checks #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bemem_port_test.sv
module bemem_port_test;
    localparam int AW = 11;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_store;
    logic [10:0] req_addr;
    logic [1:0]  req_size;
    logic [63:0] req_wdata;
    logic        busy;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        mis_err;

    int checks = 0;
    int errors = 0;
    logic [63:0] mdl [256];

    always #5 clk = ~clk;

    bemem_port uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .mis_err(mis_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return 1 << sz;
    endfunction

    function automatic logic [63:0] exp_load(input logic [10:0] a, input logic [1:0] sz);
        logic [63:0] r = '0;
        int off = int'(a[2:0]);
        for (int k = 0; k < nbytes(sz); k++)
            r = (r << 8) | 64'(mdl[a[10:3]][63 - 8*(off+k) -: 8]);
        return r;
    endfunction

    function automatic void mdl_store(input logic [10:0] a, input logic [1:0] sz, input logic [63:0] d);
        int n = nbytes(sz);
        int off = int'(a[2:0]);
        for (int k = 0; k < n; k++)
            mdl[a[10:3]][63 - 8*(off+k) -: 8] = d[8*(n-1-k) +: 8];
    endfunction

    function automatic logic legal(input logic [10:0] a, input logic [1:0] sz);
        return (int'(a[2:0]) % nbytes(sz)) == 0;
    endfunction

    task automatic do_store(input logic [10:0] a, input logic [1:0] sz, input logic [63:0] d, input string req);
        @(negedge clk);
        req_valid = 1; req_store = 1; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        if (!legal(a, sz)) begin
            chk({req, " R4 mis_err"}, 64'(mis_err), 64'd1);
            chk({req, " R4 no busy"}, 64'(busy), 64'd0);
        end else if (sz != 2'd3) begin
            chk({req, " R5 busy"}, 64'(busy), 64'd1);
            mdl_store(a, sz, d);
            @(negedge clk);
            chk({req, " R5 busy clear"}, 64'(busy), 64'd0);
        end else begin
            chk({req, " R6 no busy"}, 64'(busy), 64'd0);
            mdl_store(a, sz, d);
        end
    endtask

    task automatic do_load(input logic [10:0] a, input logic [1:0] sz, input string req);
        @(negedge clk);
        req_valid = 1; req_store = 0; req_addr = a; req_size = sz; req_wdata = '0;
        @(negedge clk);
        req_valid = 0;
        if (legal(a, sz)) begin
            chk({req, " rd_valid"}, 64'(rd_valid), 64'd1);
            chk({req, " rd_data"}, rd_data, exp_load(a, sz));
        end else begin
            chk({req, " R4 mis_err"}, 64'(mis_err), 64'd1);
            chk({req, " R4 rd_data zero"}, rd_data, 64'd0);
            chk({req, " R4 rd_valid"}, 64'(rd_valid), 64'd0);
        end
    endtask

    task automatic t_reset;
        chk("R9 busy", 64'(busy), 0);
        chk("R9 rd_valid", 64'(rd_valid), 0);
        chk("R9 mis_err", 64'(mis_err), 0);
        chk("R9 rd_data", rd_data, 0);
    endtask

    task automatic t_unwritten;
        do_load(11'h040, 2'd3, "R3 unwritten 8B");
        do_load(11'h7FF, 2'd0, "R3 unwritten 1B");
        do_load(11'h104, 2'd2, "R3 unwritten 4B");
    endtask

    task automatic t_full_and_lanes;
        do_store(11'h010, 2'd3, 64'h0123_4567_89AB_CDEF, "R6 full store");
        do_load(11'h010, 2'd3, "R6 full readback");
        for (int o = 0; o < 8; o++)
            do_load(11'h010 + 11'(o), 2'd0, "R2 byte lane");
        for (int o = 0; o < 8; o += 2)
            do_load(11'h010 + 11'(o), 2'd1, "R2 half lane");
        do_load(11'h010, 2'd2, "R2 word lane hi");
        do_load(11'h014, 2'd2, "R2 word lane lo");
        do_store(11'h010, 2'd3, 64'hFFFF_0000_FFFF_0000, "R6 overwrite");
        do_load(11'h010, 2'd3, "R6 overwrite readback");
    endtask

    task automatic t_narrow;
        for (int o = 0; o < 8; o++)
            do_store(11'h028 + 11'(o), 2'd0, 64'(8'hA0 + o), "R5 byte store");
        do_load(11'h028, 2'd3, "R5 bytes merged");
        do_store(11'h02A, 2'd1, 64'h0000_BEEF, "R5 half store");
        do_store(11'h02C, 2'd2, 64'h1122_3344, "R5 word store");
        do_load(11'h028, 2'd3, "R5 merge keeps others");
        do_store(11'h030, 2'd0, 64'h5A, "R1 adjacent word");
        do_load(11'h028, 2'd3, "R1 index separation");
        do_load(11'h030, 2'd3, "R1 new word");
        do_store(11'h7FE, 2'd1, 64'hC0DE, "R1 top word");
        do_load(11'h7F8, 2'd3, "R1 top word readback");
    endtask

    task automatic t_misaligned;
        do_store(11'h010, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R6 base");
        do_store(11'h011, 2'd1, 64'h0, "R4 misaligned half");
        do_store(11'h012, 2'd2, 64'h0, "R4 misaligned word");
        do_store(11'h014, 2'd3, 64'h0, "R4 misaligned dword");
        do_load(11'h010, 2'd3, "R4 memory unchanged");
        do_load(11'h013, 2'd1, "R4 misaligned load");
        @(negedge clk);
        chk("R4 err one cycle", 64'(mis_err), 64'd0);
    endtask

    task automatic t_upper_ignored;
        do_store(11'h050, 2'd3, 64'h0, "R7 clear");
        do_store(11'h052, 2'd0, 64'hDEAD_BEEF_CAFE_0077, "R7 byte hi junk");
        do_store(11'h054, 2'd1, 64'hFFFF_FFFF_FFFF_1234, "R7 half hi junk");
        do_load(11'h050, 2'd3, "R7 upper bits ignored");
    endtask

    task automatic t_busy_ignore;
        do_store(11'h060, 2'd3, 64'h1111_1111_1111_1111, "R8 setup");
        @(negedge clk);
        req_valid = 1; req_store = 1; req_addr = 11'h058; req_size = 2'd0; req_wdata = 64'h99;
        mdl_store(11'h058, 2'd0, 64'h99);
        @(negedge clk);
        chk("R8 busy", 64'(busy), 64'd1);
        req_store = 1; req_addr = 11'h060; req_size = 2'd3; req_wdata = 64'h0;
        @(negedge clk);
        req_valid = 0;
        chk("R8 no busy after", 64'(busy), 64'd0);
        chk("R8 no mis_err", 64'(mis_err), 64'd0);
        do_load(11'h060, 2'd3, "R8 busy store ignored");
        do_load(11'h058, 2'd3, "R8 narrow store landed");
        @(negedge clk);
        req_valid = 1; req_store = 1; req_addr = 11'h068; req_size = 2'd1; req_wdata = 64'h7777;
        mdl_store(11'h068, 2'd1, 64'h7777);
        @(negedge clk);
        req_store = 0; req_addr = 11'h061; req_size = 2'd1;
        @(negedge clk);
        req_valid = 0;
        chk("R8 busy load no rd_valid", 64'(rd_valid), 64'd0);
        chk("R8 busy misaligned no err", 64'(mis_err), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = '0;
        rst = 1; req_valid = 0; req_store = 0; req_addr = '0; req_size = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_unwritten();
        t_full_and_lanes();
        t_narrow();
        t_misaligned();
        t_upper_ignored();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(10 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule